// File: doc/BRIEF.md
# Batch-Advanced Countdown Timer

This block is a local interrupt timer whose notion of time arrives in batches instead of one tick per clock. Each update strobe carries the number of CPU cycles that elapsed since the last update. The block divides that count by a power of two, chosen by a programmable shift, to get timer ticks, and takes the ticks off the current count. When the ticks reach or pass the remaining count, the timer expires and emits a single-cycle interrupt pulse, unless the mask input is set.

In one-shot mode an expired timer parks at zero and ignores further batches until it is reloaded. In periodic mode the part of the batch that went past expiry is not lost. It is carried into the next period, reduced modulo the initial count, so the reload value is the initial count minus that remainder. When the overshoot is shorter than one period the reload takes one cycle. Otherwise a bit-serial remainder unit does the reduction, and the block reports busy and refuses updates until it is done. Writing a new initial count restarts the timer at once and cancels any reduction still in flight. An initial count of zero leaves the timer stopped.

Top module: `cyc_batch_timer`

## Requirements
- R1: After reset, `cur_count` is 0, `busy` is 0 and `irq_pulse` is 0, and the timer is stopped.
- R2: A `cfg_load` strobe sets the initial count and `cur_count` to `cfg_init` on the next cycle, clears `busy` and cancels any reload in progress, so that no late reload overwrites the new count.
- R3: The ticks of an update equal `upd_cycles` shifted right by `cfg_shift` (a 3-bit amount, 0 to 7).
- R4: If the ticks are strictly less than the current count, the count drops by the ticks and no interrupt is raised.
- R5: If the ticks are equal to or greater than the current count, `irq_pulse` is high for exactly one cycle, the cycle after the accepting edge. In one-shot mode (`cfg_periodic`=0) the count becomes 0 and stays 0 through later updates.
- R6: In periodic mode, when the overshoot (ticks minus current count) is less than the initial count, the count reloads one cycle later to the initial count minus the overshoot, and `busy` stays 0.
- R7: In periodic mode, when the overshoot is at least the initial count, `busy` rises, the count reads 0 while the remainder is formed, and the count then becomes the initial count minus (overshoot modulo the initial count). Only one interrupt pulse is produced for that update.
- R8: With `cfg_mask`=1 an expiry raises no interrupt, but the count still decrements and reloads as it would without the mask.
- R9: While the initial count is 0 no update changes the count or raises an interrupt.
- R10: An update strobe presented while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Write strobe for the initial count |
| cfg_init | input | CNT_W | Initial count value |
| cfg_periodic | input | 1 | 1 = periodic, 0 = one-shot |
| cfg_mask | input | 1 | 1 = suppress the interrupt |
| cfg_shift | input | SHIFT_W | Cycles-to-ticks right-shift amount |
| upd_valid | input | 1 | Elapsed-cycles update strobe |
| upd_cycles | input | CYC_W | Elapsed CPU cycles for this update |
| busy | output | 1 | Periodic reload remainder in progress |
| cur_count | output | CNT_W | Current count |
| irq_pulse | output | 1 | One-cycle timer interrupt |

## Verification
The interrupt pulse and any count change on the one-cycle path are registered, so they are due one clock after the edge that accepts the update. The bench samples them on the next falling edge. On the long reload path, `busy` shows at that same falling edge, and the final count arrives with the falling of `busy`, which is the width of the comparison plus one cycle later. The scoreboard monitor therefore checks the pulse and `busy` at the first falling edge, then waits for `busy` to drop before it compares the count, and counts any stray pulses in between. The reload abort is checked once more many cycles after the load, to show that no late result lands.

// File: rtl/batch_timer_pkg.sv
package batch_timer_pkg;
  typedef enum logic [1:0] {
    TS_STOP   = 2'd0,
    TS_RUN    = 2'd1,
    TS_RELOAD = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/batch_timer_scale.sv
module batch_timer_scale #(
  parameter int CYC_W   = 32,
  parameter int SHIFT_W = 3
) (
  input  logic [CYC_W-1:0]   cycles_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [CYC_W-1:0]   ticks_o
);
  localparam int NSH = 1 << SHIFT_W;

  logic [CYC_W-1:0] cand [NSH];

  for (genvar s = 0; s < NSH; s++) begin : g_sh
    assign cand[s] = cycles_i >> s;
  end

  assign ticks_o = cand[shift_i];
endmodule

// File: rtl/batch_timer_rem.sv
module batch_timer_rem #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] rem_o
);
  localparam int CB = (W > 1) ? $clog2(W) : 1;

  logic          active_q, done_q;
  logic [CB-1:0] cnt_q;
  logic [W-1:0]  dvd_q, div_q;
  logic [W:0]    rem_q, trial, rem_nx;

  always_comb begin
    trial  = {rem_q[W-1:0], dvd_q[W-1]};
    rem_nx = (trial >= {1'b0, div_q}) ? (trial - {1'b0, div_q}) : trial;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      dvd_q    <= '0;
      div_q    <= '0;
      rem_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        active_q <= 1'b0;
      end else if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= CB'(W - 1);
        dvd_q    <= dividend_i;
        div_q    <= divisor_i;
        rem_q    <= '0;
      end else if (active_q) begin
        dvd_q <= dvd_q << 1;
        rem_q <= rem_nx;
        if (cnt_q == '0) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CB'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q[W-1:0];
endmodule

// File: rtl/cyc_batch_timer.sv
module cyc_batch_timer
  import batch_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int CYC_W   = 32,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_load,
  input  logic [CNT_W-1:0]   cfg_init,
  input  logic               cfg_periodic,
  input  logic               cfg_mask,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               upd_valid,
  input  logic [CYC_W-1:0]   upd_cycles,
  output logic               busy,
  output logic [CNT_W-1:0]   cur_count,
  output logic               irq_pulse
);
  localparam int CMP_W = (CNT_W > CYC_W) ? CNT_W : CYC_W;

  tmr_state_e       state_q;
  logic [CNT_W-1:0] init_q, cur_q;
  logic             irq_q;

  logic [CYC_W-1:0] ticks;
  logic [CMP_W-1:0] ticks_x, cur_x, init_x, over_x, mod_rem;
  logic             running, expire, fast, mod_start, mod_done;

  batch_timer_scale #(.CYC_W(CYC_W), .SHIFT_W(SHIFT_W)) u_scale (
    .cycles_i(upd_cycles),
    .shift_i (cfg_shift),
    .ticks_o (ticks)
  );

  always_comb begin
    ticks_x   = CMP_W'(ticks);
    cur_x     = CMP_W'(cur_q);
    init_x    = CMP_W'(init_q);
    over_x    = ticks_x - cur_x;
    running   = (state_q == TS_RUN) && upd_valid && !cfg_load;
    expire    = running && (ticks_x >= cur_x);
    fast      = over_x < init_x;
    mod_start = expire && cfg_periodic && !fast;
  end

  batch_timer_rem #(.W(CMP_W)) u_rem (
    .clk       (clk),
    .rst       (rst),
    .start_i   (mod_start),
    .abort_i   (cfg_load),
    .dividend_i(over_x),
    .divisor_i (init_x),
    .done_o    (mod_done),
    .rem_o     (mod_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TS_STOP;
      init_q  <= '0;
      cur_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_load) begin
        init_q  <= cfg_init;
        cur_q   <= cfg_init;
        state_q <= (cfg_init != '0) ? TS_RUN : TS_STOP;
      end else begin
        case (state_q)
          TS_RUN: begin
            if (running && !expire) begin
              cur_q <= cur_q - CNT_W'(ticks_x);
            end else if (expire) begin
              irq_q <= !cfg_mask;
              if (!cfg_periodic) begin
                cur_q   <= '0;
                state_q <= TS_STOP;
              end else if (fast) begin
                cur_q <= init_q - CNT_W'(over_x);
              end else begin
                cur_q   <= '0;
                state_q <= TS_RELOAD;
              end
            end
          end
          TS_RELOAD: begin
            if (mod_done) begin
              cur_q   <= init_q - CNT_W'(mod_rem);
              state_q <= TS_RUN;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy      = (state_q == TS_RELOAD);
  assign cur_count = cur_q;
  assign irq_pulse = irq_q;
endmodule

// File: rtl/batch_timer_chk.sv
module batch_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic [CNT_W-1:0] cfg_init,
  input logic             cfg_mask,
  input logic             upd_valid,
  input logic             busy,
  input logic [CNT_W-1:0] cur_count,
  input logic             irq_pulse,
  input logic [CNT_W-1:0] init_q
);
  // R1
  always @(posedge clk) begin
    if (rst) begin
      reset_quiet_chk: assert (!irq_pulse || $past(rst) == 1'b0)
        else $error("pulse right after reset");
    end
  end

  // R2
  load_applies_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_load) |-> (cur_count == $past(cfg_init)) && !busy);

  // R5
  irq_from_update_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(upd_valid) && !$past(busy) && !$past(cfg_load));

  // R8
  mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> !$past(cfg_mask));

  // R7
  count_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    cur_count <= init_q);

  // R9
  zero_init_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(init_q) == '0) |-> !irq_pulse);

  // R10
  busy_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !irq_pulse);
endmodule

bind cyc_batch_timer batch_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_load (cfg_load),
  .cfg_init (cfg_init),
  .cfg_mask (cfg_mask),
  .upd_valid(upd_valid),
  .busy     (busy),
  .cur_count(cur_count),
  .irq_pulse(irq_pulse),
  .init_q   (init_q)
);

// File: tb/cyc_batch_timer_bench.sv
module cyc_batch_timer_bench;
  localparam int CNT_W = 32, CYC_W = 32, SHIFT_W = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_load = 1'b0;
  logic [CNT_W-1:0]   cfg_init = '0;
  logic               cfg_periodic = 1'b0;
  logic               cfg_mask = 1'b0;
  logic [SHIFT_W-1:0] cfg_shift = '0;
  logic               upd_valid = 1'b0;
  logic [CYC_W-1:0]   upd_cycles = '0;
  logic               busy, irq_pulse;
  logic [CNT_W-1:0]   cur_count;

  always #4 clk = ~clk;

  cyc_batch_timer #(.CNT_W(CNT_W), .CYC_W(CYC_W), .SHIFT_W(SHIFT_W)) u_cyc_batch_timer (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_init(cfg_init),
    .cfg_periodic(cfg_periodic), .cfg_mask(cfg_mask), .cfg_shift(cfg_shift),
    .upd_valid(upd_valid), .upd_cycles(upd_cycles),
    .busy(busy), .cur_count(cur_count), .irq_pulse(irq_pulse)
  );

  typedef struct {
    logic        irq;
    logic        slow;
    longint      cur;
    logic [23:0] tag;
  } exp_t;

  exp_t   q[$];
  exp_t   it;
  logic   have = 1'b0;
  int     extra = 0;
  int     n_chk = 0, n_bad = 0;
  logic   done_flag = 1'b0;

  longint m_cur = 0, m_init = 0;
  logic   m_run = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: compares results as they become due
  always @(negedge clk) begin
    if (!rst) begin
      if (have && busy) extra += irq_pulse;
      if (!have && q.size() > 0) begin
        it = q.pop_front();
        have = 1'b1;
        extra = 0;
        check({it.tag, " irq"}, longint'(irq_pulse), longint'(it.irq));
        check({it.tag, " busy"}, longint'(busy), longint'(it.slow));
      end
      if (have && !busy) begin
        check({it.tag, " count"}, longint'(cur_count), it.cur);
        check({it.tag, " one pulse"}, longint'(extra), 0);
        have = 1'b0;
      end
    end
  end

  task automatic do_load(input longint v);
    @(negedge clk);
    cfg_load = 1'b1; cfg_init = CNT_W'(v);
    @(negedge clk);
    cfg_load = 1'b0;
    check("R2 load count", longint'(cur_count), v);
    check("R2 load busy", longint'(busy), 0);
    m_cur = v; m_init = v; m_run = (v != 0);
  endtask

  task automatic do_update(input longint cycles, input logic [23:0] tag, input logic poke);
    exp_t e;
    longint ticks, over;
    ticks = cycles >> cfg_shift;
    e.irq = 1'b0; e.slow = 1'b0; e.tag = tag;
    if (m_run) begin
      if (ticks < m_cur) m_cur = m_cur - ticks;
      else begin
        e.irq = !cfg_mask;
        over = ticks - m_cur;
        if (!cfg_periodic) begin m_cur = 0; m_run = 1'b0; end
        else begin e.slow = (over >= m_init); m_cur = m_init - (over % m_init); end
      end
    end
    e.cur = m_cur;
    @(negedge clk);
    upd_valid = 1'b1; upd_cycles = CYC_W'(cycles);
    @(posedge clk);
    q.push_back(e);
    @(negedge clk);
    upd_valid = 1'b0;
    if (poke) begin
      // R10: a strobe during busy must be ignored
      @(negedge clk);
      upd_valid = 1'b1; upd_cycles = 32'd999;
      @(negedge clk);
      upd_valid = 1'b0;
    end
    while (have || q.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count", longint'(cur_count), 0);
    check("R1 busy", longint'(busy), 0);
    check("R1 irq", longint'(irq_pulse), 0);

    do_update(500, "R9", 1'b0);
    do_load(0);
    do_update(70, "R9", 1'b0);

    do_load(100);
    do_update(30, "R4", 1'b0);
    cfg_shift = 3'd2;
    do_update(40, "R3", 1'b0);
    cfg_shift = 3'd7;
    do_update(1280, "R3", 1'b0);
    cfg_shift = 3'd0;
    do_update(50, "R5", 1'b0);
    do_update(500, "R5", 1'b0);

    cfg_periodic = 1'b1;
    do_load(100);
    do_update(130, "R6", 1'b0);
    do_update(70, "R6", 1'b0);
    do_update(1000, "R7", 1'b0);
    do_update(357, "R7", 1'b0);
    cfg_mask = 1'b1;
    do_update(50, "R8", 1'b0);
    do_update(400, "R8", 1'b0);
    cfg_mask = 1'b0;
    do_update(10000, "R10", 1'b1);

    // R2: load during a long reload cancels it
    @(negedge clk);
    upd_valid = 1'b1; upd_cycles = 32'd5000;
    @(negedge clk);
    upd_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 busy before load", longint'(busy), 1);
    do_load(200);
    repeat (45) @(negedge clk);
    check("R2 no late reload", longint'(cur_count), 200);
    check("R2 idle", longint'(busy), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule